// File: doc/BRIEF.md
# Debug Bus Access Gate

This block stands between the request side of a debug access port and a system bus master port. It turns each debugger read or write into a single bus transfer with an address phase and a data phase. Before a transfer is issued, it checks the request against the current reset phase and answers refused requests itself with an error.

After the block reset, or whenever the system reset input rises, a security-evaluation window of `EVAL_CYCLES` cycles opens. While it is open, every request is refused. When the window closes, a status output rises. If the system reset is still held at that point, only the private peripheral region can be reached. When the system reset is released, the whole address space can be reached.

A rising edge on the debug abort input produces a one-cycle sideband pulse, which resets the interconnect. It also drops any transfer that is still outstanding.

Top module: `dbg_bus_gate`

## Requirements
- R1: After `rst_n` is released, `init_done` stays 0 for exactly `EVAL_CYCLES` rising clock edges and then reads 1. While it is 0, every request is refused.
- R2: A refused request is accepted in its cycle. `rsp_valid=1` with `rsp_err=1` appears one cycle later, and `htrans` stays IDLE (2'b00), so nothing reaches the bus.
- R3: A rise of `sys_rst_req` clears `init_done` after `SYNC_STAGES`+1 edges and restarts the full window.
- R4: Once the window has closed with `sys_rst_req` still high, addresses 0xE0000000 to 0xE00FFFFF are forwarded and all other addresses are refused.
- R5: With `sys_rst_req` low after the window, every address is forwarded.
- R6: A forwarded request shows exactly one address-phase cycle with `htrans`=NONSEQ (2'b10), followed by IDLE. SEQ (2'b11) and BUSY (2'b01) never occur. `haddr`, `hsize` and `hwrite` equal the request, unaligned addresses and byte or halfword sizes included.
- R7: The write data appears unchanged on `hwdata` in the data phase. Read data on `hrdata` returns unchanged on `rsp_rdata`: little-endian, with byte k at bits 8k+7:8k. `rsp_err` equals `hresp`, and the response comes one cycle after the data phase completes. With no wait states, the response comes 3 cycles after acceptance.
- R8: Each cycle with `hready`=0 in the data phase adds one cycle of response latency.
- R9: Each rising edge of `abort_req` gives a `habort` pulse exactly one cycle long in the following cycle. Holding `abort_req` high gives only one pulse.
- R10: An abort drops an outstanding transfer. The transfer gets `rsp_err=1` in the same cycle as `habort`, the bus returns to IDLE, and `req_ready` is 1 again.
- R11: `req_ready` is 0 from acceptance of a forwarded request until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| sys_rst_req | input | 1 | System reset level, asynchronous, synchronized inside |
| abort_req | input | 1 | Debug port abort request level |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Transfer size, log2 bytes |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | DATA_W | Read data |
| init_done | output | 1 | Evaluation window over |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Bus transfer type |
| hwrite | output | 1 | Bus write |
| hsize | output | 3 | Bus size |
| hwdata | output | DATA_W | Bus write data |
| hrdata | input | DATA_W | Bus read data |
| hready | input | 1 | Bus ready |
| hresp | input | 1 | Bus error response |
| habort | output | 1 | Sideband interconnect abort pulse |

## Verification
The bench targets the following corner cases:
- **Window length.** It counts the edges of the evaluation window exactly. A counter off by one would raise `init_done` a cycle early or late.
- **Region edges.** It probes the last word of the private region and the first address past it while reset is held. A decode mask one bit too wide or too narrow would leak or refuse one of them.
- **Sizes and alignment.** It sends unaligned byte and halfword writes. Any lane steering or realignment would show up as a changed `haddr` or `hwdata`.
- **Abort in a wait state.** It aborts a transfer that is stalled in a long wait state and holds the abort level high. A design that waits for the bus would never answer, and one that decodes the level rather than the edge would pulse `habort` repeatedly.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
   typedef enum logic [1:0] {
      PH_EVAL = 2'd0,
      PH_HELD = 2'd1,
      PH_FULL = 2'd2
   } phase_e;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_ADDR = 2'd1,
      XS_DATA = 2'd2
   } xfer_e;

   localparam logic [1:0] HT_IDLE   = 2'b00;
   localparam logic [1:0] HT_NONSEQ = 2'b10;
endpackage

// File: rtl/dbg_reset_phase.sv
module dbg_reset_phase
   import dbg_gate_pkg::*;
#(
   parameter int EVAL_CYCLES = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sys_rst_req,
   output phase_e phase_o
);
   localparam int CNT_W = $clog2(EVAL_CYCLES + 1);

   if (EVAL_CYCLES < 1) begin : g_bad_eval
      $error("EVAL_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic sys_rst_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign sys_rst_s = sys_rst_req;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
         end else begin
            chain[0] <= sys_rst_req;
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign sys_rst_s = chain[SYNC_STAGES-1];
   end

   logic             rst_seen;
   logic [CNT_W-1:0] win_cnt;
   phase_e           phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_seen <= 1'b0;
         win_cnt  <= '0;
         phase_q  <= PH_EVAL;
      end else begin
         rst_seen <= sys_rst_s;
         if (sys_rst_s && !rst_seen) begin
            phase_q <= PH_EVAL;
            win_cnt <= '0;
         end else begin
            unique case (phase_q)
               PH_EVAL: begin
                  if (win_cnt == CNT_W'(EVAL_CYCLES - 1))
                     phase_q <= sys_rst_s ? PH_HELD : PH_FULL;
                  else
                     win_cnt <= win_cnt + 1'b1;
               end
               PH_HELD: if (!sys_rst_s) phase_q <= PH_FULL;
               default: phase_q <= PH_FULL;
            endcase
         end
      end
   end

   assign phase_o = phase_q;
endmodule

// File: rtl/dbg_region_decode.sv
module dbg_region_decode
   import dbg_gate_pkg::*;
#(
   parameter int                ADDR_W        = 32,
   parameter logic [ADDR_W-1:0] PPB_BASE      = 32'hE000_0000,
   parameter int                PPB_SPAN_LOG2 = 20
) (
   input  logic [ADDR_W-1:0] addr,
   input  phase_e            phase,
   output logic              allow
);
   localparam logic [ADDR_W-1:0] SPAN_MASK = (ADDR_W'(1) << PPB_SPAN_LOG2) - 1'b1;
   localparam logic [ADDR_W-1:0] HI_MASK   = ~SPAN_MASK;

   if (PPB_SPAN_LOG2 < 1 || PPB_SPAN_LOG2 >= ADDR_W) begin : g_bad_span
      $error("PPB_SPAN_LOG2 out of range");
   end
   if ((PPB_BASE & SPAN_MASK) != '0) begin : g_bad_base
      $error("PPB_BASE not aligned to its span");
   end

   logic in_ppb;
   assign in_ppb = (addr & HI_MASK) == PPB_BASE;

   always_comb begin
      unique case (phase)
         PH_FULL: allow = 1'b1;
         PH_HELD: allow = in_ppb;
         default: allow = 1'b0;
      endcase
   end
endmodule

// File: rtl/dbg_xfer_engine.sv
module dbg_xfer_engine
   import dbg_gate_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_req,
   input  logic              allow,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] haddr,
   output logic [1:0]        htrans,
   output logic              hwrite,
   output logic [2:0]        hsize,
   output logic [DATA_W-1:0] hwdata,
   input  logic [DATA_W-1:0] hrdata,
   input  logic              hready,
   input  logic              hresp,
   output logic              habort
);
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_dw
      $error("DATA_W must be a power of two of at least 8");
   end

   xfer_e             state;
   logic              abort_q;
   logic              abort_edge;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [2:0]        size_q;
   logic              write_q;

   assign abort_edge = abort_req & ~abort_q;
   assign req_ready  = (state == XS_IDLE) && !abort_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= XS_IDLE;
         abort_q   <= 1'b0;
         habort    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
         addr_q    <= '0;
         wdata_q   <= '0;
         size_q    <= '0;
         write_q   <= 1'b0;
      end else begin
         abort_q   <= abort_req;
         habort    <= abort_edge;
         rsp_valid <= 1'b0;
         if (abort_edge) begin
            if (state != XS_IDLE) begin
               rsp_valid <= 1'b1;
               rsp_err   <= 1'b1;
               rsp_rdata <= '0;
            end
            state <= XS_IDLE;
         end else begin
            unique case (state)
               XS_IDLE: begin
                  if (req_valid) begin
                     if (allow) begin
                        state   <= XS_ADDR;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        size_q  <= req_size;
                        write_q <= req_write;
                     end else begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_rdata <= '0;
                     end
                  end
               end
               XS_ADDR: if (hready) state <= XS_DATA;
               XS_DATA: begin
                  if (hready) begin
                     state     <= XS_IDLE;
                     rsp_valid <= 1'b1;
                     rsp_err   <= hresp;
                     rsp_rdata <= write_q ? '0 : hrdata;
                  end
               end
               default: state <= XS_IDLE;
            endcase
         end
      end
   end

   assign htrans = (state == XS_ADDR) ? HT_NONSEQ : HT_IDLE;
   assign haddr  = addr_q;
   assign hsize  = size_q;
   assign hwrite = write_q;
   assign hwdata = wdata_q;
endmodule

// File: rtl/dbg_bus_gate.sv
module dbg_bus_gate
   import dbg_gate_pkg::*;
#(
   parameter int                ADDR_W        = 32,
   parameter int                DATA_W        = 32,
   parameter int                EVAL_CYCLES   = 64,
   parameter int                SYNC_STAGES   = 2,
   parameter logic [ADDR_W-1:0] PPB_BASE      = 32'hE000_0000,
   parameter int                PPB_SPAN_LOG2 = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_rst_req,
   input  logic              abort_req,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              init_done,
   output logic [ADDR_W-1:0] haddr,
   output logic [1:0]        htrans,
   output logic              hwrite,
   output logic [2:0]        hsize,
   output logic [DATA_W-1:0] hwdata,
   input  logic [DATA_W-1:0] hrdata,
   input  logic              hready,
   input  logic              hresp,
   output logic              habort
);
   phase_e phase;
   logic   allow;

   dbg_reset_phase #(
      .EVAL_CYCLES (EVAL_CYCLES),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .sys_rst_req (sys_rst_req),
      .phase_o     (phase)
   );

   dbg_region_decode #(
      .ADDR_W        (ADDR_W),
      .PPB_BASE      (PPB_BASE),
      .PPB_SPAN_LOG2 (PPB_SPAN_LOG2)
   ) u_decode (
      .addr  (req_addr),
      .phase (phase),
      .allow (allow)
   );

   dbg_xfer_engine #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort_req (abort_req),
      .allow     (allow),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata),
      .haddr     (haddr),
      .htrans    (htrans),
      .hwrite    (hwrite),
      .hsize     (hsize),
      .hwdata    (hwdata),
      .hrdata    (hrdata),
      .hready    (hready),
      .hresp     (hresp),
      .habort    (habort)
   );

   assign init_done = (phase != PH_EVAL);
endmodule

// File: rtl/dbg_bus_gate_chk.sv
module dbg_bus_gate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       rsp_valid,
   input logic       rsp_err,
   input logic       init_done,
   input logic [1:0] htrans,
   input logic       hready,
   input logic       habort
);
   a_r6_single_nonseq: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans == 2'b10 && hready) |=> (htrans == 2'b00));

   a_r6_no_seq_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans == 2'b00 || htrans == 2'b10));

   a_r2_refused_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !init_done) |=> (htrans == 2'b00 && rsp_valid && rsp_err));

   a_r9_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      habort |=> !habort);

   a_r10_abort_idles_bus: assert property (@(posedge clk) disable iff (!rst_n)
      habort |-> (htrans == 2'b00));

   a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans == 2'b10) |-> !req_ready);
endmodule

bind dbg_bus_gate dbg_bus_gate_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .init_done (init_done),
   .htrans    (htrans),
   .hready    (hready),
   .habort    (habort)
);

// File: tb/tb_dbg_bus_gate.sv
module tb_dbg_bus_gate;
   localparam int EVAL = 8;
   localparam int SYNC = 2;
   localparam logic [31:0] RD_KEY = 32'h5A5A_A5A5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sys_rst_req = 1'b0;
   logic        abort_req = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid, rsp_err, init_done, hwrite, hready, hresp, habort;
   logic [31:0] rsp_rdata, haddr, hwdata, hrdata;
   logic [1:0]  htrans;
   logic [2:0]  hsize;

   int vectors = 0;
   int miscompares = 0;

   always #4 clk = ~clk;

   dbg_bus_gate #(.EVAL_CYCLES(EVAL), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req), .abort_req(abort_req),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .init_done(init_done), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
      .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
      .hresp(hresp), .habort(habort));

   // bus slave model with programmable wait states
   int          wait_cfg = 0;
   int          rem = 0;
   logic        dp = 1'b0;
   logic [31:0] cap_addr = '0, cap_wdata = '0;
   logic [2:0]  cap_size = '0;
   logic        cap_write = 1'b0;
   int          nonseq_cnt = 0, bad_trans = 0, habort_cnt = 0, edges = 0;

   assign hready = !(dp && rem != 0);
   assign hrdata = dp ? (cap_addr ^ RD_KEY) : '0;
   assign hresp  = dp && hready && (cap_addr[31:28] == 4'h4);

   always @(posedge clk) begin
      edges <= rst_n ? edges + 1 : 0;
      if (habort) habort_cnt <= habort_cnt + 1;
      if (htrans == 2'b11 || htrans == 2'b01) bad_trans <= bad_trans + 1;
      if (habort) dp <= 1'b0;
      else if (htrans == 2'b10 && hready) begin
         nonseq_cnt <= nonseq_cnt + 1;
         dp <= 1'b1; rem <= wait_cfg;
         cap_addr <= haddr; cap_size <= hsize; cap_write <= hwrite;
      end else if (dp && hready) begin
         dp <= 1'b0; cap_wdata <= hwdata;
      end else if (dp) rem <= rem - 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   task automatic issue(input logic wr, input logic [31:0] a, input logic [2:0] sz,
                        input logic [31:0] wd, output logic err,
                        output logic [31:0] rd, output int lat);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 60) begin @(negedge clk); lat++; end
      err = rsp_err; rd = rsp_rdata;
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      chk(req_ready == 1'b1, "R11", "ready at reset", 32'(req_ready), 1);
      chk(htrans == 2'b00, "R6", "htrans at reset", 32'(htrans), 0);
      chk(habort == 1'b0, "R9", "habort at reset", 32'(habort), 0);
      chk(rsp_valid == 1'b0, "R2", "rsp_valid at reset", 32'(rsp_valid), 0);
      chk(init_done == 1'b0, "R1", "init_done at reset", 32'(init_done), 0);
   endtask

   task automatic t_eval_window();
      logic e; logic [31:0] d; int l; int n0;
      n0 = nonseq_cnt;
      issue(1'b0, 32'hE000_0000, 3'd2, '0, e, d, l);
      chk(e == 1'b1, "R1", "request refused in window", 32'(e), 1);
      chk(l == 1, "R2", "refusal latency", 32'(l), 1);
      chk(nonseq_cnt == n0, "R2", "refused request reached bus", 32'(nonseq_cnt), 32'(n0));
      while (!init_done && edges < 100) @(negedge clk);
      chk(edges == EVAL, "R1", "window length in edges", 32'(edges), 32'(EVAL));
   endtask

   task automatic t_held_phase();
      int drop_k = 0, rise_k = 0; logic e; logic [31:0] d; int l; int n0;
      @(negedge clk);
      sys_rst_req = 1'b1;
      for (int k = 1; k < 40 && rise_k == 0; k++) begin
         @(negedge clk);
         if (!init_done && drop_k == 0) drop_k = k;
         if (init_done && drop_k != 0) rise_k = k;
      end
      chk(drop_k == SYNC + 1, "R3", "init_done drop edge", 32'(drop_k), 32'(SYNC + 1));
      chk(rise_k == SYNC + 1 + EVAL, "R3", "window restart length", 32'(rise_k), 32'(SYNC + 1 + EVAL));
      issue(1'b0, 32'hE000_0010, 3'd2, '0, e, d, l);
      chk(e == 1'b0, "R4", "private region base read", 32'(e), 0);
      chk(d == (32'hE000_0010 ^ RD_KEY), "R4", "private read data", d, 32'hE000_0010 ^ RD_KEY);
      issue(1'b0, 32'hE00F_FFFC, 3'd2, '0, e, d, l);
      chk(e == 1'b0, "R4", "private region last word", 32'(e), 0);
      n0 = nonseq_cnt;
      issue(1'b0, 32'hE010_0000, 3'd2, '0, e, d, l);
      chk(e == 1'b1 && l == 1, "R4", "just past private region refused", {e, 31'(l)}, {1'b1, 31'd1});
      issue(1'b1, 32'h2000_0000, 3'd2, 32'h1, e, d, l);
      chk(e == 1'b1, "R4", "main memory refused while held", 32'(e), 1);
      chk(nonseq_cnt == n0, "R4", "refused requests on bus", 32'(nonseq_cnt), 32'(n0));
      sys_rst_req = 1'b0;
      repeat (SYNC + 3) @(negedge clk);
   endtask

   task automatic t_full_access();
      logic e; logic [31:0] d; int l; int n0;
      issue(1'b0, 32'h2000_0000, 3'd2, '0, e, d, l);
      chk(e == 1'b0, "R5", "main memory read allowed", 32'(e), 0);
      chk(d == (32'h2000_0000 ^ RD_KEY), "R7", "read data passthrough", d, 32'h2000_0000 ^ RD_KEY);
      chk(l == 3, "R7", "zero-wait latency", 32'(l), 3);
      n0 = nonseq_cnt;
      issue(1'b1, 32'h2000_0003, 3'd0, 32'hAB00_00CD, e, d, l);
      chk(nonseq_cnt == n0 + 1, "R6", "one address phase per request", 32'(nonseq_cnt), 32'(n0 + 1));
      chk(cap_addr == 32'h2000_0003, "R6", "unaligned haddr", cap_addr, 32'h2000_0003);
      chk(cap_size == 3'd0 && cap_write, "R6", "byte size and write", {28'(cap_size), cap_write}, {28'd0, 1'b1});
      chk(cap_wdata == 32'hAB00_00CD, "R7", "byte write data unchanged", cap_wdata, 32'hAB00_00CD);
      issue(1'b1, 32'h2000_0006, 3'd1, 32'h1234_5678, e, d, l);
      chk(cap_size == 3'd1 && cap_addr == 32'h2000_0006, "R6", "halfword haddr", cap_addr, 32'h2000_0006);
      chk(cap_wdata == 32'h1234_5678, "R7", "halfword write data unchanged", cap_wdata, 32'h1234_5678);
      issue(1'b0, 32'h4000_0100, 3'd2, '0, e, d, l);
      chk(e == 1'b1 && l == 3, "R7", "bus error passed to response", {e, 31'(l)}, {1'b1, 31'd3});
      chk(bad_trans == 0, "R6", "SEQ or BUSY seen", 32'(bad_trans), 0);
   endtask

   task automatic t_wait_states();
      int l = 0; int busy_ready = 0;
      wait_cfg = 4;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h2000_0040; req_size = 3'd2;
      @(negedge clk);
      req_valid = 1'b0;
      l = 1;
      while (!rsp_valid && l < 60) begin
         if (req_ready) busy_ready++;
         @(negedge clk); l++;
      end
      chk(l == 3 + 4, "R8", "latency with 4 wait states", 32'(l), 7);
      chk(busy_ready == 0, "R11", "ready while outstanding", 32'(busy_ready), 0);
      chk(rsp_rdata == (32'h2000_0040 ^ RD_KEY), "R8", "data after waits", rsp_rdata, 32'h2000_0040 ^ RD_KEY);
      wait_cfg = 0;
   endtask

   task automatic t_abort();
      int a0; logic e; logic [31:0] d; int l;
      wait_cfg = 20;
      a0 = habort_cnt;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h2000_0080; req_size = 3'd2;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      abort_req = 1'b1;
      @(negedge clk);
      chk(habort == 1'b1, "R9", "habort after abort edge", 32'(habort), 1);
      chk(rsp_valid && rsp_err, "R10", "dropped transfer error", {rsp_valid, 31'(rsp_err)}, {1'b1, 31'd1});
      chk(htrans == 2'b00 && req_ready, "R10", "bus idle and ready", {htrans, 30'(req_ready)}, {2'b00, 30'd1});
      @(negedge clk);
      chk(habort == 1'b0, "R9", "habort width", 32'(habort), 0);
      repeat (3) @(negedge clk);
      chk(habort_cnt == a0 + 1, "R9", "pulses for one held abort", 32'(habort_cnt), 32'(a0 + 1));
      abort_req = 1'b0;
      wait_cfg = 0;
      repeat (2) @(negedge clk);
      issue(1'b0, 32'hE000_0004, 3'd2, '0, e, d, l);
      chk(e == 1'b0 && d == (32'hE000_0004 ^ RD_KEY), "R10", "access after abort", d, 32'hE000_0004 ^ RD_KEY);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_eval_window();
      t_held_phase();
      t_full_access();
      t_wait_states();
      t_abort();
      repeat (2) @(negedge clk);
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      report();
   end
endmodule